// File: doc/BRIEF.md
# Sixty-Four Source Interrupt Controller

This block gathers 64 external interrupt lines into a single interrupt request. Software configures it through a small 32-bit word-addressed register port. Each source has two configuration words. The first holds a two-bit enable field and a two-bit sense selector. The second holds an 8-bit priority. A source becomes pending either as a level, which follows the input every cycle, or as a latched edge. Only the four sources 47 to 50 can latch edges. A latched edge stays set until software writes a clear command that names the source.

An arbiter picks the enabled pending source with the largest priority. On equal priority the lower source number wins. A non-zero mask level removes sources whose priority is at or below that level. The winner's number is reported in the top byte of a status register. The code 63 in that byte means that no source qualifies. A global detection enable gates sensing and candidacy. A separate output enable gates the request pin.

Register offsets, with `n` the source number:

| Register | Offset |
|---|---|
| Detection enable | 0x004 |
| Mask level | 0x084 |
| Edge clear | 0x0C0 |
| Status | 0x144 |
| Output enable | 0x444 |
| Configuration word A | 0x200 + 8·n |
| Configuration word B | 0x200 + 8·n + 4 |

Top module: `xirq_top`

## Requirements
- R1: After reset, every configuration word, the detection enable, the output enable, the mask level and all edge latches are zero. `irqReq` is low, and the status register reads 0x3F000000.
- R2: Source n's first configuration word is at offset 0x200+8n and its second is at 0x200+8n+4. Both read back exactly what was written.
- R3: A source is a candidate only when bits 29:28 of its first word are both 1. The value 01 leaves it unable to raise a request.
- R4: The following applies to a source outside 47..50, and to an edge-capable source whose bit 25 is 0. Its pending state is the input, inverted when bit 24 is 0, sampled on each clock edge while detection is enabled. Level high is code 1 and level low is code 0. On other sources, codes 3 and 2 act as level high and level low.
- R5: On sources 47..50, sense code 3 (bits 25:24) latches a rising edge and code 2 latches a falling edge. The latch stays set after the input returns.
- R6: The following write to offset 0x0C0 clears the edge latch of the source in 47..50 whose number's low 4 bits equal data bits 3:0: a write with data bit 8 set. Without bit 8 nothing is cleared. An edge that arrives in the same cycle as the clear keeps the latch set.
- R7: Status offset 0x144 reports the winning source number in bits 31:24 and zero in the other bits. The value 63 means that no source qualifies.
- R8: The winner is the candidate with the largest priority, taken from bits 7:0 of its second word. Ties go to the lower source number.
- R9: Mask level offset 0x084 holds 8 bits. When it is non-zero, sources with priority at or below it are not candidates. Zero masks nothing.
- R10: Bit 0 at offset 0x004 enables detection. When it is 0, no source is a candidate, and no level or edge state is captured. Bit 0 at offset 0x444 gates `irqReq` without changing status.
- R11: A read returns data one cycle after `busRe` is sampled. Reads of the edge-clear offset and of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Register write strobe |
| busRe | input | 1 | Register read strobe |
| busAddr | input | 12 | Byte offset of the register, word aligned |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after a read |
| srcLines | input | 64 | Interrupt source inputs |
| irqReq | output | 1 | Outgoing interrupt request |

## Verification
The hardest situation to reach from the ports is a new edge that arrives in the very cycle in which the clear command for the same source is written.

The stimulus first latches a rising edge on source 48 and lets the input fall. It then raises the input at the same falling clock edge at which it drives the clear write. As a result, the edge detector and the clear strobe meet at one rising edge. The status read that follows must still show source 48.

A second clear with a quiet input must then remove it. This separates clear-priority logic from a clear path that does not work at all.

// File: rtl/xirq_pkg.sv
`timescale 1ns/1ps
package xirq_pkg;
  localparam int NUM_SRC   = 64;
  localparam int IDX_W     = $clog2(NUM_SRC);
  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 32;
  localparam int CLR_IDX_W = 4;

  // register offsets
  localparam logic [ADDR_W-1:0] OFS_DET  = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_MASK = 12'h084;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 12'h0C0;
  localparam logic [ADDR_W-1:0] OFS_STAT = 12'h144;
  localparam logic [ADDR_W-1:0] OFS_CFG  = 12'h200;
  localparam logic [ADDR_W-1:0] OFS_OUT  = 12'h444;

  // field positions
  localparam int EN_HI       = 29;
  localparam int EN_LO       = 28;
  localparam int SENSE_HI    = 25;
  localparam int SENSE_LO    = 24;
  localparam int CLR_ARM_BIT = 8;
  localparam int STAT_LSB    = 24;

  typedef enum logic [2:0] {
    RD_NONE, RD_DET, RD_MASK, RD_STAT, RD_OUT, RD_CFGA, RD_CFGB
  } rdSel_e;

  typedef struct packed {
    logic             wrDet;
    logic             wrOut;
    logic             wrMask;
    logic             edgeClr;
    logic             wrCfgA;
    logic             wrCfgB;
    logic [IDX_W-1:0] cfgIdx;
    logic             rdStb;
    rdSel_e           rdSel;
  } strobe_t;
endpackage

// File: rtl/xirq_ctrl.sv
`timescale 1ns/1ps
module xirq_ctrl
  import xirq_pkg::*;
#(
  parameter int NSRC = NUM_SRC
) (
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              clrArm,
  output strobe_t           stb
);
  localparam int CFG_SPAN = NSRC * 8;

  logic              aligned;
  logic              isCfg;
  logic [ADDR_W-1:0] cfgOfs;
  logic              hiWord;

  always_comb begin
    aligned = (busAddr[1:0] == 2'b00);
    cfgOfs  = busAddr - OFS_CFG;
    isCfg   = aligned && (busAddr >= OFS_CFG) && (cfgOfs < ADDR_W'(CFG_SPAN));
    hiWord  = cfgOfs[2];

    stb        = '0;
    stb.cfgIdx = cfgOfs[IDX_W+2:3];
    stb.rdStb  = busRe;
    stb.rdSel  = RD_NONE;

    if (busWe) begin
      stb.wrDet   = (busAddr == OFS_DET);
      stb.wrOut   = (busAddr == OFS_OUT);
      stb.wrMask  = (busAddr == OFS_MASK);
      stb.edgeClr = (busAddr == OFS_CLR) && clrArm;
      stb.wrCfgA  = isCfg && !hiWord;
      stb.wrCfgB  = isCfg && hiWord;
    end

    if (isCfg)                      stb.rdSel = hiWord ? RD_CFGB : RD_CFGA;
    else if (busAddr == OFS_DET)    stb.rdSel = RD_DET;
    else if (busAddr == OFS_OUT)    stb.rdSel = RD_OUT;
    else if (busAddr == OFS_MASK)   stb.rdSel = RD_MASK;
    else if (busAddr == OFS_STAT)   stb.rdSel = RD_STAT;
  end
endmodule

// File: rtl/xirq_arb.sv
`timescale 1ns/1ps
module xirq_arb #(
  parameter int NSRC   = 64,
  parameter int PRIO_W = 8,
  localparam int IDW   = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]             candVec,
  input  logic [NSRC-1:0][PRIO_W-1:0] prioVec,
  output logic [IDW-1:0]              winId,
  output logic                        anyCand
);
  localparam logic [IDW-1:0] NONE_ID = IDW'(NSRC - 1);

  logic [PRIO_W-1:0] bestPrio;
  logic [IDW-1:0]    bestId;
  logic              found;

  // Scan from the top index down; ">=" lets a lower index take a tie.
  always_comb begin
    bestPrio = '0;
    bestId   = NONE_ID;
    found    = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (candVec[i] && (!found || prioVec[i] >= bestPrio)) begin
        found    = 1'b1;
        bestPrio = prioVec[i];
        bestId   = IDW'(i);
      end
    end
    anyCand = found;
    winId   = found ? bestId : NONE_ID;
  end
endmodule

// File: rtl/xirq_datapath.sv
`timescale 1ns/1ps
module xirq_datapath
  import xirq_pkg::*;
#(
  parameter int NSRC    = NUM_SRC,
  parameter int PRIO_W  = 8,
  parameter int EDGE_LO = 47,
  parameter int EDGE_HI = 50,
  localparam int IDW    = $clog2(NSRC),
  localparam int NEDGE  = EDGE_HI - EDGE_LO + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [NSRC-1:0]   srcLines,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqReq,
  output logic              detEn,
  output logic              outEn,
  output logic [NSRC-1:0]   candVec,
  output logic [NSRC-1:0]   lvlVec,
  output logic [NEDGE-1:0]  edgeLatch,
  output logic [IDW-1:0]    winId,
  output logic              anyCand
);
  logic [DATA_W-1:0] cfgA [NSRC];
  logic [DATA_W-1:0] cfgB [NSRC];
  logic [PRIO_W-1:0] maskLvl;
  logic [NSRC-1:0]   pendVec;
  logic [NSRC-1:0]   lvlNext;
  logic [NEDGE-1:0]  prevEdge;
  logic [NSRC-1:0][PRIO_W-1:0] prioVec;
  logic [IDW-1:0]    idx;

  assign idx = IDW'(stb.cfgIdx);

  // configuration and global registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NSRC; i++) begin
        cfgA[i] <= '0;
        cfgB[i] <= '0;
      end
      detEn   <= 1'b0;
      outEn   <= 1'b0;
      maskLvl <= '0;
    end else begin
      if (stb.wrCfgA) cfgA[idx] <= busWdata;
      if (stb.wrCfgB) cfgB[idx] <= busWdata;
      if (stb.wrDet)  detEn     <= busWdata[0];
      if (stb.wrOut)  outEn     <= busWdata[0];
      if (stb.wrMask) maskLvl   <= busWdata[PRIO_W-1:0];
    end
  end

  // per-source level sensing and candidacy
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic enOk, prioPass;
    assign lvlNext[g] = detEn & (cfgA[g][SENSE_LO] ? srcLines[g] : ~srcLines[g]);
    assign prioVec[g] = cfgB[g][PRIO_W-1:0];
    assign enOk       = &cfgA[g][EN_HI:EN_LO];
    assign prioPass   = (maskLvl == '0) || (prioVec[g] > maskLvl);
    if (g >= EDGE_LO && g <= EDGE_HI) begin : g_edgeSel
      assign pendVec[g] = cfgA[g][SENSE_HI] ? edgeLatch[g-EDGE_LO] : lvlVec[g];
    end else begin : g_lvlOnly
      assign pendVec[g] = lvlVec[g];
    end
    assign candVec[g] = detEn & pendVec[g] & enOk & prioPass;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lvlVec <= '0;
    else       lvlVec <= lvlNext;
  end

  // edge latches for the edge-capable window
  for (genvar k = 0; k < NEDGE; k++) begin : g_edge
    localparam int SRC = EDGE_LO + k;
    logic edgeMode, riseSel, evt, hit;
    assign edgeMode = cfgA[SRC][SENSE_HI];
    assign riseSel  = cfgA[SRC][SENSE_LO];
    assign evt = detEn & edgeMode &
                 (riseSel ? (srcLines[SRC] & ~prevEdge[k])
                          : (~srcLines[SRC] & prevEdge[k]));
    assign hit = stb.edgeClr & (busWdata[CLR_IDX_W-1:0] == CLR_IDX_W'(SRC));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        edgeLatch[k] <= 1'b0;
        prevEdge[k]  <= 1'b0;
      end else begin
        edgeLatch[k] <= evt | (edgeLatch[k] & ~hit);
        prevEdge[k]  <= srcLines[SRC];
      end
    end
  end

  xirq_arb #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
    .candVec (candVec),
    .prioVec (prioVec),
    .winId   (winId),
    .anyCand (anyCand)
  );

  assign irqReq = anyCand & outEn;

  // registered read port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata <= '0;
    end else if (stb.rdStb) begin
      case (stb.rdSel)
        RD_DET:  busRdata <= DATA_W'(detEn);
        RD_OUT:  busRdata <= DATA_W'(outEn);
        RD_MASK: busRdata <= DATA_W'(maskLvl);
        RD_STAT: busRdata <= DATA_W'(winId) << STAT_LSB;
        RD_CFGA: busRdata <= cfgA[idx];
        RD_CFGB: busRdata <= cfgB[idx];
        default: busRdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/xirq_top.sv
`timescale 1ns/1ps
module xirq_top
  import xirq_pkg::*;
#(
  parameter int NSRC    = NUM_SRC,
  parameter int PRIO_W  = 8,
  parameter int EDGE_LO = 47,
  parameter int EDGE_HI = 50,
  localparam int IDW    = $clog2(NSRC),
  localparam int NEDGE  = EDGE_HI - EDGE_LO + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [NSRC-1:0]   srcLines,
  output logic              irqReq
);
  strobe_t          stb;
  logic             detEn, outEn, anyCand;
  logic [NSRC-1:0]  candVec, lvlVec;
  logic [NEDGE-1:0] edgeLatch;
  logic [IDW-1:0]   winId;

  xirq_ctrl #(.NSRC(NSRC)) u_ctrl (
    .busWe   (busWe),
    .busRe   (busRe),
    .busAddr (busAddr),
    .clrArm  (busWdata[CLR_ARM_BIT]),
    .stb     (stb)
  );

  xirq_datapath #(
    .NSRC(NSRC), .PRIO_W(PRIO_W), .EDGE_LO(EDGE_LO), .EDGE_HI(EDGE_HI)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .busWdata  (busWdata),
    .srcLines  (srcLines),
    .busRdata  (busRdata),
    .irqReq    (irqReq),
    .detEn     (detEn),
    .outEn     (outEn),
    .candVec   (candVec),
    .lvlVec    (lvlVec),
    .edgeLatch (edgeLatch),
    .winId     (winId),
    .anyCand   (anyCand)
  );
endmodule

// File: rtl/xirq_chk.sv
`timescale 1ns/1ps
module xirq_chk #(
  parameter int NSRC  = 64,
  parameter int NEDGE = 4,
  localparam int IDW  = $clog2(NSRC)
) (
  input logic             clk,
  input logic             rstN,
  input logic             irqReq,
  input logic             detEn,
  input logic             outEn,
  input logic             anyCand,
  input logic             clrStb,
  input logic [NSRC-1:0]  candVec,
  input logic [NSRC-1:0]  lvlVec,
  input logic [NEDGE-1:0] edgeLatch,
  input logic [IDW-1:0]   winId
);
  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (detEn && outEn));

  // R7
  idle_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    !anyCand |-> (winId == IDW'(NSRC - 1)));

  // R8
  win_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyCand |-> candVec[winId]);

  // R6
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(clrStb) |-> ((edgeLatch & $past(edgeLatch)) == $past(edgeLatch)));

  // R10
  level_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(detEn) |-> (lvlVec == '0));
endmodule

bind xirq_top xirq_chk #(.NSRC(NSRC), .NEDGE(NEDGE)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .irqReq    (irqReq),
  .detEn     (detEn),
  .outEn     (outEn),
  .anyCand   (anyCand),
  .clrStb    (stb.edgeClr),
  .candVec   (candVec),
  .lvlVec    (lvlVec),
  .edgeLatch (edgeLatch),
  .winId     (winId)
);

// File: tb/sim_xirq_top.sv
`timescale 1ns/1ps
module sim_xirq_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [63:0] srcLines = '0;
  logic        irqReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit reported = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;

  xirq_top u0 (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .srcLines(srcLines), .irqReq(irqReq)
  );

  localparam logic [11:0] A_DET = 12'h004, A_MASK = 12'h084, A_CLR = 12'h0C0,
                          A_STAT = 12'h144, A_OUT = 12'h444;

  function automatic logic [11:0] cfgAddr(int n, bit hi);
    return 12'(12'h200 + 8 * n + (hi ? 4 : 0));
  endfunction

  function automatic logic [31:0] cfgWord(logic [1:0] en, logic [1:0] sense);
    return {2'b00, en, 2'b00, sense, 24'h0};
  endfunction

  function automatic logic [31:0] stat(int n);
    return 32'(n) << 24;
  endfunction

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  // driver: issue a read and push the expected word to the scoreboard
  task automatic rdExp(logic [11:0] a, logic [31:0] e, string tag);
    busRe = 1'b1; busAddr = a;
    expQ.push_back(e); tagQ.push_back(tag);
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic chkIrq(logic e, string tag);
    checks++;
    if (irqReq !== e) begin
      fails++;
      $display("FAIL %s irqReq got=%0b exp=%0b", tag, irqReq, e);
    end
  endtask

  // monitor: compare read data the cycle after a sampled read
  initial begin
    forever begin
      @(posedge clk);
      if (busRe) begin
        @(negedge clk);
        if (expQ.size() > 0) begin
          logic [31:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          checks++;
          if (busRdata !== e) begin
            fails++;
            $display("FAIL %s rdata got=%h exp=%h", t, busRdata, e);
          end
        end
      end
    end
  end

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1 got=timeout exp=finish");
      report();
      $finish;
    end
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);

    // R1 reset state
    chkIrq(1'b0, "R1 reset irq");
    rdExp(A_STAT, 32'h3F00_0000, "R1 reset status");
    rdExp(cfgAddr(5, 0), 32'h0, "R1 reset cfgA");
    rdExp(A_DET, 32'h0, "R1 reset detEn");
    rdExp(A_OUT, 32'h0, "R1 reset outEn");

    wr(A_DET, 32'h1);
    wr(A_OUT, 32'h1);

    // R2 configuration placement and readback
    wr(cfgAddr(5, 0), cfgWord(2'b11, 2'd1));
    wr(cfgAddr(5, 1), 32'h0002_000A);
    rdExp(cfgAddr(5, 0), 32'h3100_0000, "R2 cfgA readback");
    rdExp(cfgAddr(5, 1), 32'h0002_000A, "R2 cfgB readback");

    // R4 level high follows input; R7 status
    srcLines[5] = 1'b1; step();
    chkIrq(1'b1, "R4 level high asserted");
    rdExp(A_STAT, stat(5), "R7 status src5");
    srcLines[5] = 1'b0; step();
    chkIrq(1'b0, "R4 level high released");

    // R3 enable field must be 11
    wr(cfgAddr(5, 0), cfgWord(2'b01, 2'd1));
    srcLines[5] = 1'b1; step();
    chkIrq(1'b0, "R3 partial enable");
    wr(cfgAddr(5, 0), cfgWord(2'b11, 2'd1));
    chkIrq(1'b1, "R3 full enable");

    // R8 priority and tie
    wr(cfgAddr(9, 0), cfgWord(2'b11, 2'd1));
    wr(cfgAddr(9, 1), 32'd20);
    srcLines[9] = 1'b1; step();
    rdExp(A_STAT, stat(9), "R8 higher priority wins");
    wr(cfgAddr(9, 1), 32'd10);
    rdExp(A_STAT, stat(5), "R8 tie to lower index");

    // R9 mask level
    wr(A_MASK, 32'd10);
    chkIrq(1'b0, "R9 masked at level");
    rdExp(A_STAT, 32'h3F00_0000, "R9 masked status");
    wr(A_MASK, 32'd9);
    rdExp(A_STAT, stat(5), "R9 above mask");
    rdExp(A_MASK, 32'd9, "R9 mask readback");
    wr(A_MASK, 32'd0);

    // R10 global gates
    wr(A_DET, 32'h0); step();
    chkIrq(1'b0, "R10 detection off");
    rdExp(A_STAT, 32'h3F00_0000, "R10 detection off status");
    wr(A_DET, 32'h1); step();
    chkIrq(1'b1, "R10 detection on");
    wr(A_OUT, 32'h0);
    chkIrq(1'b0, "R10 output off");
    rdExp(A_STAT, stat(5), "R10 status kept with output off");
    wr(A_OUT, 32'h1);

    // R4 level low
    srcLines[5] = 1'b0; srcLines[9] = 1'b0;
    wr(cfgAddr(5, 0), 32'h0);
    wr(cfgAddr(9, 0), 32'h0);
    wr(cfgAddr(6, 1), 32'd3);
    wr(cfgAddr(6, 0), cfgWord(2'b11, 2'd0));
    rdExp(A_STAT, stat(6), "R4 level low pending");
    srcLines[6] = 1'b1; step();
    rdExp(A_STAT, 32'h3F00_0000, "R4 level low idle");
    wr(cfgAddr(6, 0), 32'h0);

    // R4 edge code on a level-only source acts as level
    wr(cfgAddr(20, 1), 32'd4);
    wr(cfgAddr(20, 0), cfgWord(2'b11, 2'd3));
    srcLines[20] = 1'b1; step();
    rdExp(A_STAT, stat(20), "R4 src20 level");
    srcLines[20] = 1'b0; step();
    rdExp(A_STAT, 32'h3F00_0000, "R4 src20 no latch");
    wr(cfgAddr(20, 0), 32'h0);

    // R5 rising edge on 48
    wr(cfgAddr(48, 1), 32'd30);
    wr(cfgAddr(48, 0), cfgWord(2'b11, 2'd3));
    srcLines[48] = 1'b1; step();
    srcLines[48] = 1'b0; step();
    rdExp(A_STAT, stat(48), "R5 rising latched");
    chkIrq(1'b1, "R5 latched irq");

    // R6 clear command
    wr(A_CLR, 32'h000);
    rdExp(A_STAT, stat(48), "R6 no arm bit");
    wr(A_CLR, 32'h10F);
    rdExp(A_STAT, stat(48), "R6 other index");
    wr(A_CLR, 32'h100);
    rdExp(A_STAT, 32'h3F00_0000, "R6 cleared");
    chkIrq(1'b0, "R6 cleared irq");
    rdExp(A_CLR, 32'h0, "R11 clear reads zero");

    // R6 edge and clear in the same cycle
    srcLines[48] = 1'b1;
    wr(A_CLR, 32'h100);
    rdExp(A_STAT, stat(48), "R6 edge wins over clear");
    srcLines[48] = 1'b0;
    wr(A_CLR, 32'h100);
    rdExp(A_STAT, 32'h3F00_0000, "R6 later clear");
    wr(cfgAddr(48, 0), 32'h0);

    // R5 falling edge on 49
    wr(cfgAddr(49, 1), 32'd7);
    wr(cfgAddr(49, 0), cfgWord(2'b11, 2'd2));
    srcLines[49] = 1'b1; step();
    rdExp(A_STAT, 32'h3F00_0000, "R5 rise ignored in falling mode");
    srcLines[49] = 1'b0; step();
    rdExp(A_STAT, stat(49), "R5 falling latched");
    wr(A_CLR, 32'h101);
    rdExp(A_STAT, 32'h3F00_0000, "R6 clear src49");

    // R11 unmapped
    rdExp(12'h010, 32'h0, "R11 unmapped read");
    rdExp(A_OUT, 32'h1, "R10 outEn readback");

    step(3);
    done = 1'b1;
    report();
    $finish;
  end
endmodule